// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit takes a floating-point value in unpacked form (sign, class code, unbiased exponent, an extended mantissa and a sticky bit) and produces the 32-bit IEEE-754 single-precision word. It applies one of four rounding modes. Values too small for the normal range pass through a denormalizing shifter before rounding, so that rounding acts on the bits that actually survive. Exponents too large for the format are turned into either infinity or the largest finite magnitude, depending on sign and mode.

Alongside the packed word the unit reports a five-bit result-class code and four exception flags: inexact, rounded-up, overflow and underflow. These are combinational, in the same cycle as the inputs. A commit port folds them into a 10-bit status register. Some fields of that register are replaced on every update. The overflow, underflow and inexact-summary bits only accumulate.

Input encodings. `cls_i` is 0 zero, 1 finite number, 2 infinity, 3 NaN. `rm_i` is 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. In `mant_i`, bit 28 holds the leading one and bits 27:5 the 23 fraction bits. Bit 4 is the guard bit and bit 3 the round bit. Bits 2:0 fold into sticky, and bits 31:29 are ignored.

Top module: `spk_pack`

## Requirements
- R1: A NaN input (cls_i=3) yields sign_i, exponent 0xFF and fraction mant_i[27:5] with fraction bit 22 forced to 1. cls_o = 5'b10001, where the bits are {C, less, greater, equal, unordered} from MSB to LSB. No exception flag is set.
- R2: An infinity input yields {sign_i, 0xFF, 23'b0}. cls_o is unordered plus less (if negative) or greater (if positive).
- R3: A zero input yields a zero carrying sign_i. cls_o has the equal bit set, plus C when the sign is negative. No exception flag is set.
- R4: A finite number with biased exponent (exp_i+127) between 1 and 254 packs its fraction from mant_i[27:5]. Guard is mant_i[4], round is mant_i[3], and sticky is mant_i[2:0] ORed with sticky_i. Inexact is set when guard, round or sticky is nonzero. In nearest-even mode the value is incremented when guard is set and either round, sticky or the fraction LSB is set. Any increment sets rounded-up. cls_o is less or greater according to the sign.
- R5: When the result is inexact, toward-zero never increments. Toward +infinity increments only positive values, and toward -infinity increments only negative values.
- R6: When rounding carries the significand to 2.0, the exponent rises by one and the fraction is zero.
- R7: When the final biased exponent is 255 or more, overflow and inexact are set. The result is infinity with unordered added in nearest mode, in +infinity mode when positive, and in -infinity mode when negative. In every other case it is {sign, 0x7F7FFFFF} with no unordered bit.
- R8: When the biased exponent is 0 or below, the 29-bit significand is shifted right by 1-biased-exponent before rounding. Shifted-out bits join sticky, and shifts of 29 or more leave only sticky. An exact subnormal result packs with exponent 0 and cls_o of C plus less/greater, and no underflow.
- R9: A subnormal result that is inexact sets underflow. If its fraction rounds to zero, the output is a signed zero with only the equal bit in cls_o. Otherwise the output is C plus less/greater.
- R10: When a subnormal rounds up into the leading-one position, the result is the smallest normal {sign, 0x01, 23'b0}. cls_o is less/greater only, and underflow stays clear.
- R11: At a rising clock edge with valid_i=1 and no_upd_i=0, stat_o[4:0] takes cls_o, stat_o[5] takes rounded-up and stat_o[6] takes inexact. stat_o[7] and stat_o[8] OR in overflow and underflow, and stat_o[9] ORs in inexact.
- R12: When valid_i=0, or when no_upd_i=1, stat_o holds its value across the edge.
- R13: rst_ni low clears stat_o to 0. Bits 9:7 stay set through later commits that carry no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs carry a result to commit |
| no_upd_i | input | 1 | Suppress the status update |
| sign_i | input | 1 | Sign |
| cls_i | input | 2 | Class code (0 zero, 1 number, 2 inf, 3 NaN) |
| exp_i | input | EXP_W | Unbiased exponent, two's complement |
| mant_i | input | 32 | Significand, leading one at bit 28 |
| sticky_i | input | 1 | Sticky bit from earlier shifts |
| rm_i | input | 2 | Rounding mode |
| res_o | output | 32 | Packed single-precision word |
| cls_o | output | 5 | {C, less, greater, equal, unordered} |
| inexact_o | output | 1 | Result was rounded |
| rnd_up_o | output | 1 | Magnitude was incremented |
| ovf_o | output | 1 | Overflow |
| unf_o | output | 1 | Underflow |
| stat_o | output | 10 | Status register |

## Verification
The rounding logic is driven with mantissas whose guard, round, sticky and LSB patterns separate a tie with an even LSB from a tie with an odd LSB, a round-bit-only case from a guard-plus-sticky case, and each directed mode under both signs. Exponents are chosen on both sides of each boundary. At the top end they separate an exact maximum from a carry into overflow, and each overflow mode from the others. At the bottom end they separate an exact subnormal, a flush to signed zero, a sticky-driven round-up, promotion to the smallest normal, and a shift far past the mantissa width. Commit sequences then separate replaced status fields from accumulating ones, and the hold and idle cases from a real update.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int LEAD    = 28;
  localparam int MW      = LEAD + 1;
  localparam int LSB_POS = LEAD - FRAC_W;
  localparam int EBITS   = 8;
  localparam int BIAS    = 127;
  localparam int EMAX    = 255;
  localparam int STAT_W  = 10;
  localparam int SH_W    = 6;

  typedef enum logic [1:0] {CL_ZERO = 2'd0, CL_NUM = 2'd1, CL_INF = 2'd2, CL_NAN = 2'd3} cls_e;
  typedef enum logic [1:0] {RM_NEAR = 2'd0, RM_ZERO = 2'd1, RM_POS = 2'd2, RM_NEG = 2'd3} rm_e;

  // class code bit positions
  localparam int K_C  = 4;
  localparam int K_LT = 3;
  localparam int K_GT = 2;
  localparam int K_EQ = 1;
  localparam int K_UN = 0;
endpackage

// File: rtl/spk_denorm.sv
module spk_denorm #(
  parameter int W    = 29,
  parameter int SH_W = 6
) (
  input  logic [W-1:0]    m_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [W-1:0]    m_o,
  output logic            lost_o
);
  logic [W-1:0] mask;

  always_comb begin
    mask = '0;
    if (int'(sh_i) >= W) begin
      m_o    = '0;
      lost_o = |m_i;
    end else begin
      mask   = ~({W{1'b1}} << sh_i);
      m_o    = m_i >> sh_i;
      lost_o = |(m_i & mask);
    end
  end
endmodule

// File: rtl/spk_round.sv
module spk_round
  import spk_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic [SW-1:0] sig_i,
  input  logic          g_i,
  input  logic          r_i,
  input  logic          s_i,
  input  logic [1:0]    rm_i,
  input  logic          sign_i,
  output logic [SW:0]   res_o,
  output logic          inexact_o,
  output logic          up_o
);
  logic inc;

  always_comb begin
    inexact_o = g_i | r_i | s_i;
    inc = 1'b0;
    if (inexact_o) begin
      unique case (rm_e'(rm_i))
        RM_NEAR: inc = g_i & (r_i | s_i | sig_i[0]);
        RM_ZERO: inc = 1'b0;
        RM_POS:  inc = ~sign_i;
        RM_NEG:  inc = sign_i;
        default: inc = 1'b0;
      endcase
    end
    up_o  = inc;
    res_o = {1'b0, sig_i} + {{SW{1'b0}}, inc};
  end
endmodule

// File: rtl/spk_stat.sv
module spk_stat
  import spk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [4:0]        cls_i,
  input  logic              inexact_i,
  input  logic              rnd_up_i,
  input  logic              ovf_i,
  input  logic              unf_i,
  output logic [STAT_W-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
    end else if (commit_i) begin
      stat_o[6:0] <= {inexact_i, rnd_up_i, cls_i};
      stat_o[7]   <= stat_o[7] | ovf_i;
      stat_o[8]   <= stat_o[8] | unf_i;
      stat_o[9]   <= stat_o[9] | inexact_i;
    end
  end
endmodule

// File: rtl/spk_pack.sv
module spk_pack
  import spk_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              no_upd_i,
  input  logic              sign_i,
  input  logic [1:0]        cls_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [31:0]       mant_i,
  input  logic              sticky_i,
  input  logic [1:0]        rm_i,
  output logic [31:0]       res_o,
  output logic [4:0]        cls_o,
  output logic              inexact_o,
  output logic              rnd_up_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam int BE_W = EXP_W + 2;
  localparam logic signed [BE_W-1:0] BE_BIAS  = BE_W'(BIAS);
  localparam logic signed [BE_W-1:0] BE_TOP   = BE_W'(EMAX);
  localparam logic signed [BE_W-1:0] BE_ONE   = BE_W'(1);
  localparam logic signed [BE_W-1:0] BE_CLAMP = -BE_W'(MW);
  localparam logic [EBITS-1:0]  E_ALL1   = '1;
  localparam logic [EBITS-1:0]  E_MAXF   = E_ALL1 - 1'b1;
  localparam logic [FRAC_W-1:0] Q_BIT    = 1 << (FRAC_W - 1);

  logic signed [BE_W-1:0] be, fbe;
  logic                   sub;
  logic [SH_W-1:0]        sh;
  logic [MW-1:0]          md;
  logic                   lost;
  logic [SIG_W:0]         rs;
  logic                   r_inx, r_up, s_all, to_inf;
  logic [4:0]             side;
  logic                   unused_hi;

  assign unused_hi = ^mant_i[31:MW];

  // biased exponent and denormalizing shift
  always_comb begin
    be  = $signed({{2{exp_i[EXP_W-1]}}, exp_i}) + BE_BIAS;
    sub = (be <= 0);
    if (!sub)                sh = '0;
    else if (be < BE_CLAMP)  sh = SH_W'(MW);
    else                     sh = SH_W'(BE_ONE - be);
  end

  spk_denorm #(.W(MW), .SH_W(SH_W)) u_dn (
    .m_i   (mant_i[MW-1:0]),
    .sh_i  (sh),
    .m_o   (md),
    .lost_o(lost)
  );

  assign s_all = (|md[LSB_POS-3:0]) | lost | sticky_i;

  spk_round #(.SW(SIG_W)) u_rnd (
    .sig_i    (md[LEAD:LSB_POS]),
    .g_i      (md[LSB_POS-1]),
    .r_i      (md[LSB_POS-2]),
    .s_i      (s_all),
    .rm_i     (rm_i),
    .sign_i   (sign_i),
    .res_o    (rs),
    .inexact_o(r_inx),
    .up_o     (r_up)
  );

  always_comb begin
    fbe    = be + {{(BE_W-1){1'b0}}, rs[SIG_W]};
    to_inf = (rm_e'(rm_i) == RM_NEAR) ||
             (rm_e'(rm_i) == RM_POS && !sign_i) ||
             (rm_e'(rm_i) == RM_NEG &&  sign_i);
    side   = '0;
    side[K_LT] = sign_i;
    side[K_GT] = ~sign_i;
  end

  // result assembly
  always_comb begin
    res_o     = {sign_i, 31'b0};
    cls_o     = '0;
    inexact_o = 1'b0;
    rnd_up_o  = 1'b0;
    ovf_o     = 1'b0;
    unf_o     = 1'b0;
    unique case (cls_e'(cls_i))
      CL_ZERO: begin
        cls_o[K_EQ] = 1'b1;
        cls_o[K_C]  = sign_i;
      end
      CL_INF: begin
        res_o       = {sign_i, E_ALL1, {FRAC_W{1'b0}}};
        cls_o       = side;
        cls_o[K_UN] = 1'b1;
      end
      CL_NAN: begin
        res_o       = {sign_i, E_ALL1, mant_i[LEAD-1:LSB_POS] | Q_BIT};
        cls_o[K_C]  = 1'b1;
        cls_o[K_UN] = 1'b1;
      end
      default: begin
        inexact_o = r_inx;
        rnd_up_o  = r_up;
        if (sub) begin
          if (rs[SIG_W-1]) begin
            // rounded into the leading-one position
            res_o = {sign_i, EBITS'(1), {FRAC_W{1'b0}}};
            cls_o = side;
          end else begin
            unf_o = r_inx;
            if (r_inx && rs[FRAC_W-1:0] == '0) begin
              cls_o[K_EQ] = 1'b1;
            end else begin
              res_o      = {sign_i, {EBITS{1'b0}}, rs[FRAC_W-1:0]};
              cls_o      = side;
              cls_o[K_C] = 1'b1;
            end
          end
        end else if (fbe >= BE_TOP) begin
          ovf_o     = 1'b1;
          inexact_o = 1'b1;
          cls_o     = side;
          if (to_inf) begin
            res_o       = {sign_i, E_ALL1, {FRAC_W{1'b0}}};
            cls_o[K_UN] = 1'b1;
          end else begin
            res_o = {sign_i, E_MAXF, {FRAC_W{1'b1}}};
          end
        end else begin
          // on a carry to 2.0 rs[FRAC_W-1:0] is already zero
          res_o = {sign_i, fbe[EBITS-1:0], rs[FRAC_W-1:0]};
          cls_o = side;
        end
      end
    endcase
  end

  spk_stat u_st (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (valid_i & ~no_upd_i),
    .cls_i    (cls_o),
    .inexact_i(inexact_o),
    .rnd_up_i (rnd_up_o),
    .ovf_i    (ovf_o),
    .unf_i    (unf_o),
    .stat_o   (stat_o)
  );
endmodule

// File: rtl/spk_pack_chk.sv
module spk_pack_chk #(
  parameter int EXP_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             no_upd_i,
  input logic             sign_i,
  input logic [1:0]       cls_i,
  input logic [31:0]      res_o,
  input logic [4:0]       cls_o,
  input logic             inexact_o,
  input logic             rnd_up_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic [9:0]       stat_o
);
  a_r1_nan_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_i == 2'd3 |-> res_o[30:22] == 9'h1FF && cls_o == 5'b10001);

  a_r2_inf_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_i == 2'd2 |-> res_o[30:0] == 31'h7F800000 && cls_o[0] && !inexact_o);

  a_r3_zero_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_i == 2'd0 |-> cls_o[1] && res_o[30:0] == 31'b0 && res_o[31] == sign_i);

  a_r5_up_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_up_o |-> inexact_o);

  a_r7_ovf_inexact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> inexact_o && res_o[30:23] >= 8'hFE);

  a_r9_unf_subnormal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> inexact_o && res_o[30:23] == 8'h00);

  a_r11_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !no_upd_i |=> stat_o[6:0] == $past({inexact_o, rnd_up_o, cls_o}));

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i || no_upd_i |=> $stable(stat_o));

  a_r13_sticky_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[9] |=> stat_o[9]);
endmodule

bind spk_pack spk_pack_chk #(.EXP_W(EXP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .no_upd_i (no_upd_i),
  .sign_i   (sign_i),
  .cls_i    (cls_i),
  .res_o    (res_o),
  .cls_o    (cls_o),
  .inexact_o(inexact_o),
  .rnd_up_o (rnd_up_o),
  .ovf_o    (ovf_o),
  .unf_o    (unf_o),
  .stat_o   (stat_o)
);

// File: tb/sim_spk_pack.sv
module sim_spk_pack;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, no_upd_i = 1'b0, sign_i = 1'b0, sticky_i = 1'b0;
  logic [1:0]  cls_i = '0, rm_i = '0;
  logic [9:0]  exp_i = '0;
  logic [31:0] mant_i = '0;
  logic [31:0] res_o;
  logic [4:0]  cls_o;
  logic        inexact_o, rnd_up_o, ovf_o, unf_o;
  logic [9:0]  stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  spk_pack #(.EXP_W(10)) u0 (
    .clk_i, .rst_ni, .valid_i, .no_upd_i, .sign_i, .cls_i, .exp_i, .mant_i,
    .sticky_i, .rm_i, .res_o, .cls_o, .inexact_o, .rnd_up_o, .ovf_o, .unf_o, .stat_o
  );

  typedef struct packed {
    logic        sg;
    logic [1:0]  cl;
    logic [9:0]  ex;
    logic [31:0] mt;
    logic        st;
    logic [1:0]  rm;
    logic [31:0] res;
    logic [4:0]  cls;
    logic [3:0]  fl;   // {inexact, up, ovf, unf}
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd1,  10'sd0,   32'h10000000, 1'b0, 2'd0, 32'h3F800000, 5'b00100, 4'b0000},
    '{1'b0, 2'd3,  10'sd0,   32'h10000000, 1'b0, 2'd0, 32'h7FC00000, 5'b10001, 4'b0000},
    '{1'b1, 2'd3,  10'sd0,   32'h10024680, 1'b0, 2'd0, 32'hFFC01234, 5'b10001, 4'b0000},
    '{1'b1, 2'd2,  10'sd0,   32'h00000000, 1'b0, 2'd0, 32'hFF800000, 5'b01001, 4'b0000},
    '{1'b0, 2'd2,  10'sd0,   32'h00000000, 1'b0, 2'd1, 32'h7F800000, 5'b00101, 4'b0000},
    '{1'b1, 2'd0,  10'sd0,   32'h00000000, 1'b0, 2'd0, 32'h80000000, 5'b10010, 4'b0000},
    '{1'b0, 2'd0,  10'sd0,   32'h00000000, 1'b0, 2'd2, 32'h00000000, 5'b00010, 4'b0000},
    '{1'b0, 2'd1,  10'sd0,   32'h10000010, 1'b0, 2'd0, 32'h3F800000, 5'b00100, 4'b1000},
    '{1'b0, 2'd1,  10'sd0,   32'h10000030, 1'b0, 2'd0, 32'h3F800002, 5'b00100, 4'b1100},
    '{1'b0, 2'd1,  10'sd0,   32'h10000010, 1'b1, 2'd0, 32'h3F800001, 5'b00100, 4'b1100},
    '{1'b0, 2'd1,  10'sd0,   32'h10000008, 1'b0, 2'd0, 32'h3F800000, 5'b00100, 4'b1000},
    '{1'b0, 2'd1,  10'sd0,   32'h10000018, 1'b0, 2'd1, 32'h3F800000, 5'b00100, 4'b1000},
    '{1'b0, 2'd1,  10'sd0,   32'h10000008, 1'b0, 2'd2, 32'h3F800001, 5'b00100, 4'b1100},
    '{1'b1, 2'd1,  10'sd0,   32'h10000008, 1'b0, 2'd2, 32'hBF800000, 5'b01000, 4'b1000},
    '{1'b1, 2'd1,  10'sd0,   32'h10000008, 1'b0, 2'd3, 32'hBF800001, 5'b01000, 4'b1100},
    '{1'b0, 2'd1,  10'sd0,   32'h1FFFFFF8, 1'b0, 2'd0, 32'h40000000, 5'b00100, 4'b1100},
    '{1'b0, 2'd1,  10'sd128, 32'h10000000, 1'b0, 2'd0, 32'h7F800000, 5'b00101, 4'b1010},
    '{1'b0, 2'd1,  10'sd128, 32'h10000000, 1'b0, 2'd1, 32'h7F7FFFFF, 5'b00100, 4'b1010},
    '{1'b1, 2'd1,  10'sd128, 32'h10000000, 1'b0, 2'd2, 32'hFF7FFFFF, 5'b01000, 4'b1010},
    '{1'b1, 2'd1,  10'sd128, 32'h10000000, 1'b0, 2'd3, 32'hFF800000, 5'b01001, 4'b1010},
    '{1'b0, 2'd1,  10'sd127, 32'h1FFFFFF8, 1'b0, 2'd0, 32'h7F800000, 5'b00101, 4'b1110},
    '{1'b0, 2'd1,  10'sd127, 32'h1FFFFFE0, 1'b0, 2'd0, 32'h7F7FFFFF, 5'b00100, 4'b0000},
    '{1'b0, 2'd1, -10'sd127, 32'h10000000, 1'b0, 2'd0, 32'h00400000, 5'b10100, 4'b0000},
    '{1'b1, 2'd1, -10'sd149, 32'h10000000, 1'b0, 2'd0, 32'h80000001, 5'b11000, 4'b0000},
    '{1'b0, 2'd1, -10'sd150, 32'h10000000, 1'b0, 2'd0, 32'h00000000, 5'b00010, 4'b1001},
    '{1'b1, 2'd1, -10'sd150, 32'h10000000, 1'b0, 2'd0, 32'h80000000, 5'b00010, 4'b1001},
    '{1'b0, 2'd1, -10'sd150, 32'h10000020, 1'b0, 2'd0, 32'h00000001, 5'b10100, 4'b1101},
    '{1'b0, 2'd1, -10'sd127, 32'h1FFFFFF8, 1'b0, 2'd0, 32'h00800000, 5'b00100, 4'b1100},
    '{1'b0, 2'd1, -10'sd400, 32'h10000000, 1'b0, 2'd2, 32'h00000001, 5'b10100, 4'b1101},
    '{1'b0, 2'd1, -10'sd140, 32'h10000008, 1'b0, 2'd1, 32'h00000200, 5'b10100, 4'b1001}
  };

  localparam string TAG [NV] = '{
    "R4", "R1", "R1", "R2", "R2", "R3", "R3", "R4", "R4", "R4",
    "R4", "R5", "R5", "R5", "R5", "R6", "R7", "R7", "R7", "R7",
    "R6/R7", "R7", "R8", "R8", "R9", "R9", "R9", "R10", "R9", "R9"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    sign_i = v.sg; cls_i = v.cl; exp_i = v.ex; mant_i = v.mt;
    sticky_i = v.st; rm_i = v.rm;
  endtask

  task automatic commit(input vec_t v, input logic vl, input logic hold,
                        input logic [9:0] exp_stat, input string tag);
    @(negedge clk_i);
    drive(v);
    valid_i = vl; no_upd_i = hold;
    @(negedge clk_i);
    valid_i = 1'b0; no_upd_i = 1'b0;
    #2 chk(tag, {22'b0, stat_o}, {22'b0, exp_stat});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2 chk("R13 reset", {22'b0, stat_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i]);
      #2;
      chk(TAG[i], res_o, VEC[i].res);
      chk(TAG[i], {27'b0, cls_o}, {27'b0, VEC[i].cls});
      chk(TAG[i], {28'b0, inexact_o, rnd_up_o, ovf_o, unf_o}, {28'b0, VEC[i].fl});
    end

    @(negedge clk_i);
    #2 chk("R12 idle walk", {22'b0, stat_o}, 32'h0);

    commit(VEC[8],  1'b1, 1'b0, 10'h264, "R11 first");
    commit(VEC[0],  1'b1, 1'b0, 10'h204, "R11 replace");
    commit(VEC[16], 1'b1, 1'b1, 10'h204, "R12 no_upd");
    commit(VEC[16], 1'b0, 1'b0, 10'h204, "R12 not valid");
    commit(VEC[16], 1'b1, 1'b0, 10'h2C5, "R11 ovf");
    commit(VEC[24], 1'b1, 1'b0, 10'h3C2, "R11 unf");
    commit(VEC[0],  1'b1, 1'b0, 10'h384, "R13 sticky");

    @(negedge clk_i);
    rst_ni = 1'b0;
    #2 chk("R13 async clear", {22'b0, stat_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule